// File: doc/BRIEF.md
# Event-Filtered Debug Trace Buffer

This block watches one bus interface and records snapshots of its transactions into a 256-entry on-chip memory. Each snapshot holds the transaction address, the source ID and a 16-bit stamp from a free-running cycle counter. Software sets up the unit through a small write port. That port holds four registers: a trace-event mask, a mode word, a stop-event mask and a command word with arm and clear bits. Software then reads captured entries back by index and watches the status outputs.

The unit can run in one of two capture modes. In the first, every cycle that carries a valid transaction is stored. In the second, only cycles on which the programmed trace event fires are stored. The trace event is built from a vector of concurrent event inputs, either as an OR or as an AND over the enabled bits. Capture ends when a separately programmed stop event occurs or when the memory is full, whichever comes first. At that moment a one-clock pulse is sent out to trigger an external logic analyser.

Top module: `tcap_top`

## Requirements
- R1: After reset, state reads IDLE (state code 0; ARMED=1, TRACING=2, STOPPED=3), the write count is 0, full is 0, the stop cause is 0 and the trigger output is low.
- R2: Command register (address 3) bit 0 moves IDLE to ARMED. No entry is written while the unit is IDLE, whatever the bus does.
- R3: With mode register (address 1) bit 0 = 0, an entry is written on each cycle with busValid high while the unit is ARMED or TRACING. The first such cycle moves ARMED to TRACING.
- R4: With mode bit 0 = 1, an entry is written only on cycles where the trace event matches, and busValid has no effect.
- R5: Mode bits [2:1] select how the trace-event mask (address 0) is combined. Code 0 matches when any enabled event is high. Code 1 matches when all enabled events are high. Codes 2 and 3 never match. An all-zero mask never matches.
- R6: While TRACING, any event enabled in the stop mask (address 2) moves the unit to STOPPED with stop cause 1. While ARMED, stop events are ignored.
- R7: The 256th written entry moves the unit to STOPPED with full=1 and stop cause 2. After that, no further entries are written.
- R8: If a stop event arrives in the same cycle as the write to the last free slot, that entry is still stored, full becomes 1 and the stop cause is 1.
- R9: trigOut is high for exactly one clock, in the cycle the unit first shows STOPPED.
- R10: Command bit 1 (clear) returns the unit to IDLE with write count 0, full 0 and stop cause 0. Clear wins over arm.
- R11: An entry holds busAddr, busSrc and a stamp equal to the number of rising clock edges since reset release (mod 2^16), as seen on the capture cycle. The entry at rdAddr appears on the read outputs one clock after rdAddr is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 2 | Register select: 0 trace mask, 1 mode, 2 stop mask, 3 command |
| cfgWdata | input | 8 | Register write data |
| busValid | input | 1 | Observed interface carries a valid transaction |
| busAddr | input | 32 | Observed transaction address |
| busSrc | input | 3 | Observed transaction source ID |
| events | input | 8 | Concurrent event inputs |
| rdAddr | input | 8 | Readback entry index |
| rdBusAddr | output | 32 | Readback address field |
| rdSrc | output | 3 | Readback source ID field |
| rdStamp | output | 16 | Readback stamp field |
| stState | output | 2 | Current state code |
| stCount | output | 9 | Entries written |
| stFull | output | 1 | Memory full |
| stCause | output | 2 | Stop cause: 0 none, 1 stop event, 2 full |
| trigOut | output | 1 | One-clock pulse when tracing stops |

## Verification
Two functions can fall in the same cycle: the write into the last free slot and the detection of a programmed stop event. The bench fills 255 entries in every-valid mode. It then drives a cycle that carries a valid transaction and the stop event together. It judges the result by the full flag, by a stop cause of 1 rather than 2, by the single trigger pulse, and by reading back that final entry with its expected stamp.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ARMED   = 2'd1,
    ST_TRACING = 2'd2,
    ST_STOPPED = 2'd3
  } tcapState_e;

  typedef struct packed {
    logic wrEn;
    logic ptrClear;
  } tcapStrobe_t;

  localparam logic [1:0] CAUSE_NONE = 2'd0;
  localparam logic [1:0] CAUSE_STOP = 2'd1;
  localparam logic [1:0] CAUSE_FULL = 2'd2;

  localparam logic [1:0] COMB_ANY = 2'd0;
  localparam logic [1:0] COMB_ALL = 2'd1;
endpackage

// File: rtl/tcap_datapath.sv
module tcap_datapath
  import tcap_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int ADDRW  = 32,
  parameter int SRCW   = 3,
  parameter int STAMPW = 16,
  localparam int IDXW  = $clog2(DEPTH),
  localparam int PTRW  = IDXW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  tcapStrobe_t       strobe,
  input  logic [ADDRW-1:0]  busAddr,
  input  logic [SRCW-1:0]   busSrc,
  input  logic [IDXW-1:0]   rdAddr,
  output logic [PTRW-1:0]   wrPtr,
  output logic              lastSlot,
  output logic              full,
  output logic [ADDRW-1:0]  rdBusAddr,
  output logic [SRCW-1:0]   rdSrc,
  output logic [STAMPW-1:0] rdStamp
);
  localparam int ENTW = ADDRW + SRCW + STAMPW;
  localparam logic [PTRW-1:0] FULLCNT = PTRW'(DEPTH);

  logic [ENTW-1:0]   mem [DEPTH];
  logic [STAMPW-1:0] stampCnt;
  logic [ENTW-1:0]   rdEntry;

  assign lastSlot = (wrPtr == FULLCNT - 1'b1);
  assign full     = (wrPtr == FULLCNT);

  always_ff @(posedge clk) begin
    if (rst) stampCnt <= '0;
    else     stampCnt <= stampCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.ptrClear) wrPtr <= '0;
    else if (strobe.wrEn)       wrPtr <= wrPtr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn && !full) mem[wrPtr[IDXW-1:0]] <= {busAddr, busSrc, stampCnt};
  end

  always_ff @(posedge clk) begin
    rdEntry <= mem[rdAddr];
  end

  assign {rdBusAddr, rdSrc, rdStamp} = rdEntry;

  a_r7_ptr_no_overflow: assert property (@(posedge clk) disable iff (rst)
    wrPtr <= FULLCNT);
  a_r3_ptr_advances: assert property (@(posedge clk) disable iff (rst)
    (strobe.wrEn && !strobe.ptrClear) |=> (wrPtr == $past(wrPtr) + 1'b1));
  a_r10_ptr_cleared: assert property (@(posedge clk) disable iff (rst)
    strobe.ptrClear |=> (wrPtr == '0));
endmodule

// File: rtl/tcap_ctrl.sv
module tcap_ctrl
  import tcap_pkg::*;
#(
  parameter int EVW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfgWe,
  input  logic [1:0]     cfgAddr,
  input  logic [EVW-1:0] cfgWdata,
  input  logic           busValid,
  input  logic [EVW-1:0] events,
  input  logic           lastSlot,
  output tcapStrobe_t    strobe,
  output tcapState_e     state,
  output logic [1:0]     stopCause,
  output logic           trigOut
);
  logic [EVW-1:0] traceMask, stopMask;
  logic           eventOnly;
  logic [1:0]     combMode;
  tcapState_e     nextState;
  logic [1:0]     nextCause;
  logic           armCmd, clearCmd, traceHit, stopHit, capture, active;
  logic [EVW-1:0] masked;

  assign armCmd   = cfgWe && (cfgAddr == 2'd3) && cfgWdata[0];
  assign clearCmd = cfgWe && (cfgAddr == 2'd3) && cfgWdata[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      traceMask <= '0;
      stopMask  <= '0;
      eventOnly <= 1'b0;
      combMode  <= COMB_ANY;
    end else if (cfgWe) begin
      case (cfgAddr)
        2'd0: traceMask <= cfgWdata;
        2'd1: {combMode, eventOnly} <= cfgWdata[2:0];
        2'd2: stopMask  <= cfgWdata;
        default: ;
      endcase
    end
  end

  assign masked = events & traceMask;
  always_comb begin
    case (combMode)
      COMB_ANY: traceHit = |masked;
      COMB_ALL: traceHit = (traceMask != '0) && (masked == traceMask);
      default:  traceHit = 1'b0;
    endcase
  end

  assign stopHit = |(events & stopMask);
  assign capture = eventOnly ? traceHit : busValid;
  assign active  = (state == ST_ARMED) || (state == ST_TRACING);

  assign strobe.wrEn     = active && capture && !clearCmd;
  assign strobe.ptrClear = clearCmd;

  always_comb begin
    nextState = state;
    nextCause = stopCause;
    if (clearCmd) begin
      nextState = ST_IDLE;
      nextCause = CAUSE_NONE;
    end else begin
      case (state)
        ST_IDLE:    if (armCmd) nextState = ST_ARMED;
        ST_ARMED:   if (capture) begin
                      if (lastSlot) begin
                        nextState = ST_STOPPED;
                        nextCause = CAUSE_FULL;
                      end else begin
                        nextState = ST_TRACING;
                      end
                    end
        ST_TRACING: if (stopHit) begin
                      nextState = ST_STOPPED;
                      nextCause = CAUSE_STOP;
                    end else if (capture && lastSlot) begin
                      nextState = ST_STOPPED;
                      nextCause = CAUSE_FULL;
                    end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      stopCause <= CAUSE_NONE;
      trigOut   <= 1'b0;
    end else begin
      state     <= nextState;
      stopCause <= nextCause;
      trigOut   <= (nextState == ST_STOPPED) && (state != ST_STOPPED);
    end
  end

  a_r2_idle_no_write: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !strobe.wrEn);
  a_r9_trig_single: assert property (@(posedge clk) disable iff (rst)
    trigOut |=> !trigOut);
  a_r9_trig_on_stop: assert property (@(posedge clk) disable iff (rst)
    trigOut |-> (state == ST_STOPPED));
  a_r7_full_stops: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TRACING && capture && lastSlot && !clearCmd) |=> (state == ST_STOPPED));
  a_r6_stop_event: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TRACING && stopHit && !clearCmd) |=> (state == ST_STOPPED && stopCause == CAUSE_STOP));
  a_r10_clear_idle: assert property (@(posedge clk) disable iff (rst)
    clearCmd |=> (state == ST_IDLE && stopCause == CAUSE_NONE));
endmodule

// File: rtl/tcap_top.sv
module tcap_top
  import tcap_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cfgWe,
  input  logic [1:0]  cfgAddr,
  input  logic [7:0]  cfgWdata,
  input  logic        busValid,
  input  logic [31:0] busAddr,
  input  logic [2:0]  busSrc,
  input  logic [7:0]  events,
  input  logic [7:0]  rdAddr,
  output logic [31:0] rdBusAddr,
  output logic [2:0]  rdSrc,
  output logic [15:0] rdStamp,
  output logic [1:0]  stState,
  output logic [8:0]  stCount,
  output logic        stFull,
  output logic [1:0]  stCause,
  output logic        trigOut
);
  tcapStrobe_t strobe;
  tcapState_e  state;
  logic        lastSlot;

  tcap_ctrl #(.EVW(8)) u_ctrl (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .busValid(busValid), .events(events), .lastSlot(lastSlot),
    .strobe(strobe), .state(state), .stopCause(stCause), .trigOut(trigOut)
  );

  tcap_datapath #(.DEPTH(256), .ADDRW(32), .SRCW(3), .STAMPW(16)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .busAddr(busAddr), .busSrc(busSrc),
    .rdAddr(rdAddr), .wrPtr(stCount), .lastSlot(lastSlot), .full(stFull),
    .rdBusAddr(rdBusAddr), .rdSrc(rdSrc), .rdStamp(rdStamp)
  );

  assign stState = state;
endmodule

// File: tb/sim_tcap_top.sv
module sim_tcap_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgAddr = '0;
  logic [7:0]  cfgWdata = '0;
  logic        busValid = 1'b0;
  logic [31:0] busAddr = '0;
  logic [2:0]  busSrc = '0;
  logic [7:0]  events = '0;
  logic [7:0]  rdAddr = '0;
  logic [31:0] rdBusAddr;
  logic [2:0]  rdSrc;
  logic [15:0] rdStamp;
  logic [1:0]  stState;
  logic [8:0]  stCount;
  logic        stFull;
  logic [1:0]  stCause;
  logic        trigOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [15:0] edgeCnt = '0;
  logic [50:0] expQ[$];

  tcap_top u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // stamp model from R11: rising edges since reset release
  always @(posedge clk) begin
    if (rst) edgeCnt <= '0;
    else     edgeCnt <= edgeCnt + 16'd1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] a, input logic [7:0] d);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0; cfgWdata = '0;
  endtask

  // driver: one bus cycle, pushes the expected entry when a write is due
  task automatic drive(input logic v, input logic [31:0] a, input logic [2:0] s,
                       input logic [7:0] ev, input bit expWr);
    busValid = v; busAddr = a; busSrc = s; events = ev;
    if (expWr) expQ.push_back({a, s, edgeCnt});
    @(negedge clk);
    busValid = 1'b0; events = '0;
  endtask

  // monitor: reads entries back and pops the scoreboard
  task automatic readCompare(input int first, input int n);
    for (int i = 0; i < n; i++) begin
      logic [50:0] e;
      rdAddr = 8'(first + i);
      @(negedge clk);
      if (expQ.size() == 0) begin
        chk("R11 queue underflow", 64'd1, 64'd0);
      end else begin
        e = expQ.pop_front();
        chk("R11 entry", {13'd0, rdBusAddr, rdSrc, rdStamp}, {13'd0, e});
      end
    end
  endtask

  task automatic status(input string req, input int st, input int cnt,
                        input int fl, input int cause);
    chk({req, " state"}, 64'(stState), 64'(st));
    chk({req, " count"}, 64'(stCount), 64'(cnt));
    chk({req, " full"},  64'(stFull),  64'(fl));
    chk({req, " cause"}, 64'(stCause), 64'(cause));
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    status("R1", 0, 0, 0, 0);
    chk("R1 trig", 64'(trigOut), 64'd0);

    // R2 no writes while IDLE
    drive(1'b1, 32'h1000, 3'd1, 8'h00, 1'b0);
    status("R2 idle", 0, 0, 0, 0);
    cfg(2'd2, 8'h80);           // stop mask: event 7
    cfg(2'd1, 8'h00);           // every-valid, ANY
    cfg(2'd3, 8'h01);           // arm
    status("R2 armed", 1, 0, 0, 0);
    // R6 stop ignored while ARMED
    drive(1'b0, 32'h0, 3'd0, 8'h80, 1'b0);
    status("R6 armed ignore", 1, 0, 0, 0);
    // R3 every-valid capture
    drive(1'b1, 32'hA000_0001, 3'd2, 8'h00, 1'b1);
    status("R3 tracing", 2, 1, 0, 0);
    drive(1'b0, 32'hBAD0_0000, 3'd7, 8'h00, 1'b0);
    drive(1'b1, 32'hA000_0002, 3'd3, 8'h00, 1'b1);
    drive(1'b1, 32'hA000_0003, 3'd4, 8'h01, 1'b1);
    status("R3 count", 2, 3, 0, 0);
    // R6 stop event with a valid cycle: entry written, then stop
    drive(1'b1, 32'hA000_0004, 3'd5, 8'h80, 1'b1);
    status("R6 stopped", 3, 4, 0, 1);
    chk("R9 trig high", 64'(trigOut), 64'd1);
    drive(1'b1, 32'hBAD0_0001, 3'd0, 8'h00, 1'b0);
    chk("R9 trig low", 64'(trigOut), 64'd0);
    status("R6 hold", 3, 4, 0, 1);
    readCompare(0, 4);

    // R10 clear, clear wins over arm
    cfg(2'd3, 8'h03);
    status("R10 clear", 0, 0, 0, 0);

    // R4/R5 event-only with ALL over mask 0x03
    cfg(2'd0, 8'h03);
    cfg(2'd1, 8'h03);
    cfg(2'd3, 8'h01);
    drive(1'b1, 32'hC000_0000, 3'd1, 8'h01, 1'b0);
    status("R5 all partial", 1, 0, 0, 0);
    drive(1'b0, 32'hC000_0001, 3'd6, 8'h03, 1'b1);
    status("R4 no valid needed", 2, 1, 0, 0);
    drive(1'b1, 32'hC000_0002, 3'd2, 8'h02, 1'b0);
    drive(1'b0, 32'hC000_0003, 3'd3, 8'h07, 1'b1);
    status("R5 all extra", 2, 2, 0, 0);
    readCompare(0, 2);

    // R5 ANY mode in event-only
    cfg(2'd3, 8'h02);
    cfg(2'd1, 8'h01);
    cfg(2'd3, 8'h01);
    drive(1'b0, 32'hD000_0000, 3'd0, 8'h10, 1'b0);
    drive(1'b0, 32'hD000_0001, 3'd1, 8'h02, 1'b1);
    status("R5 any", 2, 1, 0, 0);
    readCompare(0, 1);

    // R5 combine code 2 never matches
    cfg(2'd3, 8'h02);
    cfg(2'd1, 8'h05);
    cfg(2'd3, 8'h01);
    drive(1'b1, 32'hE000_0000, 3'd0, 8'hFF, 1'b0);
    status("R5 code2", 1, 0, 0, 0);

    // R5 empty mask never matches (ANY)
    cfg(2'd3, 8'h02);
    cfg(2'd0, 8'h00);
    cfg(2'd1, 8'h01);
    cfg(2'd3, 8'h01);
    drive(1'b1, 32'hE000_0001, 3'd0, 8'hFF, 1'b0);
    status("R5 empty", 1, 0, 0, 0);

    // R7 fill in every-valid mode
    cfg(2'd3, 8'h02);
    cfg(2'd1, 8'h00);
    cfg(2'd3, 8'h01);
    for (int i = 0; i < 256; i++)
      drive(1'b1, 32'h5000_0000 + 32'(i), 3'(i), 8'h00, 1'b1);
    status("R7 full", 3, 256, 1, 2);
    chk("R9 trig full", 64'(trigOut), 64'd1);
    drive(1'b1, 32'hBAD0_0002, 3'd0, 8'h00, 1'b0);
    status("R7 no more", 3, 256, 1, 2);
    chk("R9 trig full low", 64'(trigOut), 64'd0);
    readCompare(0, 256);

    // R8 stop event coincides with last slot
    cfg(2'd3, 8'h02);
    cfg(2'd3, 8'h01);
    for (int i = 0; i < 255; i++)
      drive(1'b1, 32'h6000_0000 + 32'(i), 3'(i), 8'h00, 1'b1);
    status("R8 pre", 2, 255, 0, 0);
    drive(1'b1, 32'h6FFF_FFFF, 3'd5, 8'h80, 1'b1);
    status("R8 coincide", 3, 256, 1, 1);
    chk("R8 trig", 64'(trigOut), 64'd1);
    for (int i = 0; i < 255; i++) void'(expQ.pop_front());
    readCompare(255, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule